// File: doc/BRIEF.md
# Memory Training Rank Sequencer

This block steps a memory training pass across up to four populated ranks. A start pulse makes it train rank 0 first, then each following rank in ascending order. For each rank it asks an external training engine for one trial at a time. It keeps running trials until the required number of consecutive passing results has been seen, or until the trial budget for that rank is used up. Between ranks it can issue a programmable burst of refresh requests, one at a time over a request/acknowledge pair. No burst follows the final rank.

Three settings come from a small configuration write port: a refresh count, a repeat count and a debug enable. A separate step write feeds a single-step debug mode. While debug is enabled, each state change of the sequencer uses up one pending step. The step bit reads back as set until a state change consumes it. When the last rank is finished, a one-cycle done pulse is raised together with a per-rank pass vector.

Top module: `rank_train_seq`

## Requirements
- R1: After reset the refresh count reads 8, the repeat count reads 7, debug enable and the step bit read 0, and trn_req, ref_req, seq_done and busy are low.
- R2: Ranks are trained in ascending order from 0 to N-1. N is num_ranks, with 0 treated as 1 and values above 4 treated as 4. Each trial is one single-cycle trn_req pulse with trn_rank set to the rank index. An unpopulated rank gets no trial.
- R3: A rank passes once its trial results contain a run of consecutive passes equal to the repeat count. A repeat count of 0 counts as 1. A failing trial resets the run to zero.
- R4: A rank that has used 4 × (effective repeat count) trials without passing is marked failed, and the sequence moves on to the next rank.
- R5: After every rank except the last, exactly refresh-count refresh requests are completed before the next rank's first trial. A count of 0 gives none, and none follow the last rank. ref_req and trn_req are never high together.
- R6: Once raised, ref_req stays high until ref_ack is seen. It drops in the cycle after the acknowledge, so only one refresh is outstanding at a time.
- R7: After the last rank, seq_done pulses for exactly one cycle. rank_pass bit i is 1 exactly when rank i passed. Bits of unpopulated ranks are 0.
- R8: With debug enabled, no state change occurs unless the step bit is set. The step bit is set by a dbg_step_wr pulse, reads 1 while pending (including in idle), and reads 0 once a state change has consumed it.
- R9: One step advances exactly one state. A single-rank run whose first trial passes, with a repeat count of 1, needs four steps (issue, result, decide, finish), and seq_done appears only after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Writes the three configuration fields below |
| cfg_rfsh_cnt | input | 4 | Refreshes issued between ranks |
| cfg_repeat | input | 4 | Consecutive passes required per rank |
| cfg_dbg_en | input | 1 | Single-step debug enable |
| dbg_step_wr | input | 1 | Pulse that sets the step bit |
| num_ranks | input | 3 | Populated rank count, sampled at start |
| start | input | 1 | Starts a training pass from idle |
| trn_req | output | 1 | One-cycle trial request |
| trn_rank | output | 2 | Rank index of the current trial |
| trn_done | input | 1 | Trial finished pulse |
| trn_pass | input | 1 | Trial result, valid with trn_done |
| ref_req | output | 1 | Refresh request, held until acknowledged |
| ref_ack | input | 1 | Refresh acknowledge |
| busy | output | 1 | Sequencer is not idle |
| seq_done | output | 1 | One-cycle pulse when all ranks are finished |
| rank_pass | output | 4 | Per-rank pass flags |
| rfsh_cnt_q | output | 4 | Refresh count readback |
| repeat_q | output | 4 | Repeat count readback |
| dbg_en_q | output | 1 | Debug enable readback |
| dbg_step_q | output | 1 | Step bit readback |

## Verification
The sweep covers repeat counts of 0, 1, 2 and 7, so it hits the zero-as-one rule. A design that treated 0 literally would pass ranks without any trial result or loop forever. Pass/fail patterns include a permanently failing rank and an alternating pattern. These expose a run counter that is not cleared on failure, which would accept alternating ranks, and a budget that is off by one, which would give the wrong trial count. Refresh counts of 0, 3 and 8 are used with delayed acknowledges. These catch a burst after the last rank, a missed zero case, or a request that drops before its acknowledge. The debug test checks that a step written in idle stays pending, and that exactly four steps finish a minimal run. A design that let one step carry through two states would finish early.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_CHECK,
    ST_RFSH,
    ST_NEXT,
    ST_FINISH
  } rts_state_e;
endpackage

// File: rtl/rts_cfg_regs.sv
module rts_cfg_regs #(
  parameter int CNT_W    = 4,
  parameter int RFSH_RST = 8,
  parameter int REP_RST  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] rfsh_d,
  input  logic [CNT_W-1:0] rep_d,
  input  logic             dbg_d,
  input  logic             step_wr,
  input  logic             step_take,
  output logic [CNT_W-1:0] rfsh_q,
  output logic [CNT_W-1:0] rep_q,
  output logic             dbg_q,
  output logic             step_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rfsh_q <= CNT_W'(RFSH_RST);
      rep_q  <= CNT_W'(REP_RST);
      dbg_q  <= 1'b0;
      step_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        rfsh_q <= rfsh_d;
        rep_q  <= rep_d;
        dbg_q  <= dbg_d;
      end
      // a fresh write wins over consumption in the same cycle
      if (step_wr)        step_q <= 1'b1;
      else if (step_take) step_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rts_trial_ctr.sv
module rts_trial_ctr #(
  parameter int CNT_W     = 4,
  parameter int FAIL_MULT = 4,
  parameter int TRIAL_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             eval,
  input  logic             pass,
  input  logic [CNT_W-1:0] rep_cfg,
  output logic             rank_ok,
  output logic             rank_bad
);
  logic [CNT_W-1:0]   run_q;
  logic [TRIAL_W-1:0] trials_q;
  logic [CNT_W-1:0]   rep_eff;
  logic [TRIAL_W-1:0] limit;
  logic [CNT_W:0]     run_inc;
  logic [TRIAL_W-1:0] trial_inc;

  assign rep_eff   = (rep_cfg == '0) ? CNT_W'(1) : rep_cfg;
  assign limit     = TRIAL_W'(rep_eff) * TRIAL_W'(FAIL_MULT);
  assign run_inc   = {1'b0, run_q} + 1'b1;
  assign trial_inc = trials_q + 1'b1;
  assign rank_ok   = pass && (run_inc >= {1'b0, rep_eff});
  assign rank_bad  = !rank_ok && (trial_inc >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q    <= '0;
      trials_q <= '0;
    end else if (eval) begin
      run_q    <= pass ? run_inc[CNT_W-1:0] : '0;
      trials_q <= trial_inc;
    end
  end
endmodule

// File: rtl/rts_rfsh_burst.sv
module rts_rfsh_burst #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] count,
  input  logic             ref_ack,
  output logic             ref_req,
  output logic             finished
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      ref_req <= 1'b0;
    end else if (go) begin
      rem_q   <= count;
      ref_req <= 1'b0;
    end else if (ref_req && ref_ack) begin
      ref_req <= 1'b0;
      rem_q   <= rem_q - 1'b1;
    end else if (rem_q != '0 && !ref_req) begin
      ref_req <= 1'b1;
    end
  end

  assign finished = (rem_q == '0) && !ref_req;
endmodule

// File: rtl/rank_train_seq.sv
module rank_train_seq
  import rts_pkg::*;
#(
  parameter int MAX_RANKS = 4,
  parameter int CNT_W     = 4,
  parameter int FAIL_MULT = 4,
  parameter int RFSH_RST  = 8,
  parameter int REP_RST   = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [CNT_W-1:0]             cfg_rfsh_cnt,
  input  logic [CNT_W-1:0]             cfg_repeat,
  input  logic                         cfg_dbg_en,
  input  logic                         dbg_step_wr,
  input  logic [$clog2(MAX_RANKS+1)-1:0] num_ranks,
  input  logic                         start,
  output logic                         trn_req,
  output logic [$clog2(MAX_RANKS)-1:0] trn_rank,
  input  logic                         trn_done,
  input  logic                         trn_pass,
  output logic                         ref_req,
  input  logic                         ref_ack,
  output logic                         busy,
  output logic                         seq_done,
  output logic [MAX_RANKS-1:0]         rank_pass,
  output logic [CNT_W-1:0]             rfsh_cnt_q,
  output logic [CNT_W-1:0]             repeat_q,
  output logic                         dbg_en_q,
  output logic                         dbg_step_q
);
  localparam int RIDX_W  = $clog2(MAX_RANKS);
  localparam int NR_W    = $clog2(MAX_RANKS + 1);
  localparam int TRIAL_W = $clog2(FAIL_MULT * ((1 << CNT_W) - 1) + 1);

  rts_state_e        state_q, nxt;
  logic              want, gated, move, adv_ok, step_take;
  logic [RIDX_W-1:0] rank_q, last_q, last_idx;
  logic [NR_W-1:0]   nr_eff;
  logic              res_vld, res_pass;
  logic              rank_ok, rank_bad, rank_end;
  logic              rf_go, rf_fin, ctr_clr, ctr_eval;

  rts_cfg_regs #(.CNT_W(CNT_W), .RFSH_RST(RFSH_RST), .REP_RST(REP_RST)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .rfsh_d(cfg_rfsh_cnt), .rep_d(cfg_repeat),
    .dbg_d(cfg_dbg_en), .step_wr(dbg_step_wr), .step_take(step_take),
    .rfsh_q(rfsh_cnt_q), .rep_q(repeat_q), .dbg_q(dbg_en_q), .step_q(dbg_step_q)
  );

  rts_trial_ctr #(.CNT_W(CNT_W), .FAIL_MULT(FAIL_MULT), .TRIAL_W(TRIAL_W)) u_trial (
    .clk(clk), .rst(rst), .clr(ctr_clr), .eval(ctr_eval), .pass(res_pass),
    .rep_cfg(repeat_q), .rank_ok(rank_ok), .rank_bad(rank_bad)
  );

  rts_rfsh_burst #(.CNT_W(CNT_W)) u_rfsh (
    .clk(clk), .rst(rst), .go(rf_go), .count(rfsh_cnt_q), .ref_ack(ref_ack),
    .ref_req(ref_req), .finished(rf_fin)
  );

  // populated rank count clamped to 1..MAX_RANKS
  assign nr_eff   = (num_ranks == '0) ? NR_W'(1) :
                    (num_ranks > NR_W'(MAX_RANKS)) ? NR_W'(MAX_RANKS) : num_ranks;
  assign last_idx = RIDX_W'(nr_eff - 1'b1);
  assign rank_end = rank_ok || rank_bad;
  assign adv_ok   = !dbg_en_q || dbg_step_q;

  always_comb begin
    nxt   = state_q;
    want  = 1'b0;
    gated = 1'b1;
    unique case (state_q)
      ST_IDLE:   begin gated = 1'b0; want = start; nxt = ST_ISSUE; end
      ST_ISSUE:  begin want = 1'b1; nxt = ST_WAIT; end
      ST_WAIT:   begin want = res_vld; nxt = ST_CHECK; end
      ST_CHECK: begin
        want = 1'b1;
        if (!rank_end)                nxt = ST_ISSUE;
        else if (rank_q == last_q)    nxt = ST_FINISH;
        else if (rfsh_cnt_q != '0)    nxt = ST_RFSH;
        else                          nxt = ST_NEXT;
      end
      ST_RFSH:   begin want = rf_fin; nxt = ST_NEXT; end
      ST_NEXT:   begin want = 1'b1; nxt = ST_ISSUE; end
      ST_FINISH: begin want = 1'b1; nxt = ST_IDLE; end
      default:   begin want = 1'b1; nxt = ST_IDLE; end
    endcase
  end

  assign move      = want && (!gated || adv_ok);
  assign step_take = move && gated && dbg_en_q;
  assign ctr_eval  = move && (state_q == ST_CHECK);
  assign ctr_clr   = move && ((state_q == ST_NEXT) || (state_q == ST_IDLE));
  assign rf_go     = ctr_eval && (nxt == ST_RFSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rank_q    <= '0;
      last_q    <= '0;
      trn_req   <= 1'b0;
      seq_done  <= 1'b0;
      rank_pass <= '0;
      res_vld   <= 1'b0;
      res_pass  <= 1'b0;
    end else begin
      trn_req  <= move && (state_q == ST_ISSUE);
      seq_done <= move && (state_q == ST_FINISH);
      if (move) state_q <= nxt;
      if (move && state_q == ST_IDLE) begin
        rank_q    <= '0;
        last_q    <= last_idx;
        rank_pass <= '0;
      end
      if (move && state_q == ST_NEXT) rank_q <= rank_q + 1'b1;
      if (ctr_eval && rank_ok) rank_pass[rank_q] <= 1'b1;
      if (move && state_q == ST_WAIT) begin
        res_vld <= 1'b0;
      end else if (state_q == ST_WAIT && trn_done && !res_vld) begin
        res_vld  <= 1'b1;
        res_pass <= trn_pass;
      end
    end
  end

  assign trn_rank = rank_q;
  assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/rank_train_seq_chk.sv
module rank_train_seq_chk (
  input logic clk,
  input logic rst,
  input logic trn_req,
  input logic ref_req,
  input logic ref_ack,
  input logic seq_done,
  input logic dbg_en_q,
  input logic dbg_step_q
);
  assert_trn_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    trn_req |=> !trn_req);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(trn_req && ref_req));

  assert_ref_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_ack) |=> ref_req);

  assert_ref_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_ack) |=> !ref_req);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

  assert_step_gate_R8: assert property (@(posedge clk) disable iff (rst)
    trn_req |-> $past(!dbg_en_q || dbg_step_q));
endmodule

bind rank_train_seq rank_train_seq_chk i_chk (
  .clk(clk), .rst(rst), .trn_req(trn_req), .ref_req(ref_req), .ref_ack(ref_ack),
  .seq_done(seq_done), .dbg_en_q(dbg_en_q), .dbg_step_q(dbg_step_q)
);

// File: tb/test_rank_train_seq.sv
module test_rank_train_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, cfg_we, cfg_dbg_en, dbg_step_wr, start, trn_done, trn_pass, ref_ack;
  logic [3:0] cfg_rfsh_cnt, cfg_repeat, rfsh_cnt_q, repeat_q, rank_pass;
  logic [2:0] num_ranks;
  logic [1:0] trn_rank;
  logic       trn_req, ref_req, busy, seq_done, dbg_en_q, dbg_step_q;

  int checks = 0, fails = 0;
  int tr_cnt[4], rf_cnt[4];
  int last_rank, dly, pat, ack_dly, aw, done_cnt;
  bit pend, aw_on, ack_prev;
  logic [3:0] pass_seen;

  rank_train_seq i_rank_train_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_rfsh_cnt(cfg_rfsh_cnt),
    .cfg_repeat(cfg_repeat), .cfg_dbg_en(cfg_dbg_en), .dbg_step_wr(dbg_step_wr),
    .num_ranks(num_ranks), .start(start), .trn_req(trn_req), .trn_rank(trn_rank),
    .trn_done(trn_done), .trn_pass(trn_pass), .ref_req(ref_req), .ref_ack(ref_ack),
    .busy(busy), .seq_done(seq_done), .rank_pass(rank_pass), .rfsh_cnt_q(rfsh_cnt_q),
    .repeat_q(repeat_q), .dbg_en_q(dbg_en_q), .dbg_step_q(dbg_step_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pass_fn(input int p, input int r, input int t);
    case (p)
      0:       return 1'b1;
      1:       return (r == 2) ? 1'b0 : (t >= r);
      default: return (t % 2) == 1;
    endcase
  endfunction

  task automatic clear_stats();
    for (int i = 0; i < 4; i++) begin tr_cnt[i] = 0; rf_cnt[i] = 0; end
    last_rank = 0; dly = 0; done_cnt = 0; aw_on = 0; aw = 0; pass_seen = '0;
  endtask

  // one cycle of the training-engine and refresh-target models
  task automatic engine_cycle();
    @(negedge clk);
    ack_prev = ref_ack;
    ref_ack  = 1'b0;
    trn_done = 1'b0;
    trn_pass = 1'b0;
    if (seq_done) begin done_cnt++; pass_seen = rank_pass; end
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin trn_done = 1'b1; trn_pass = pend; end
    end
    if (trn_req) begin
      pend = pass_fn(pat, int'(trn_rank), tr_cnt[trn_rank]);
      tr_cnt[trn_rank]++;
      last_rank = int'(trn_rank);
      dly = 2;
    end
    if (ack_prev) begin
      chk(!ref_req, "R6 drop after ack", int'(ref_req), 0);
    end else if (ref_req) begin
      if (!aw_on) begin aw_on = 1; aw = ack_dly; end
      if (aw == 0) begin ref_ack = 1'b1; rf_cnt[last_rank]++; aw_on = 0; end
      else aw--;
    end else if (aw_on) begin
      chk(1'b0, "R6 held until ack", 0, 1);
      aw_on = 0;
    end
  endtask

  task automatic cfg_write(input int rf, input int rp, input bit dbg);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rfsh_cnt = 4'(rf); cfg_repeat = 4'(rp); cfg_dbg_en = dbg;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int rf, input int rp, input int nr, input int p, input int ad);
    int nre, repe, run_len, t, n;
    int exp_tr[4];
    logic [3:0] exp_vec;
    nre  = (nr == 0) ? 1 : (nr > 4 ? 4 : nr);
    repe = (rp == 0) ? 1 : rp;
    exp_vec = '0;
    for (int r = 0; r < 4; r++) begin
      exp_tr[r] = 0;
      if (r < nre) begin
        run_len = 0; t = 0;
        forever begin
          run_len = pass_fn(p, r, t) ? run_len + 1 : 0;
          t++;
          if (run_len >= repe) begin exp_vec[r] = 1'b1; break; end
          if (t >= 4 * repe) break;
        end
        exp_tr[r] = t;
      end
    end
    cfg_write(rf, rp, 1'b0);
    num_ranks = 3'(nr); pat = p; ack_dly = ad;
    clear_stats();
    start = 1'b1;
    engine_cycle();
    start = 1'b0;
    n = 0;
    while (done_cnt == 0 && n < 6000) begin engine_cycle(); n++; end
    repeat (4) engine_cycle();
    chk(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
    chk(pass_seen == exp_vec, "R7 pass vector", int'(pass_seen), int'(exp_vec));
    for (int r = 0; r < 4; r++) begin
      if (r >= nre)          chk(tr_cnt[r] == 0, "R2 unpopulated rank", tr_cnt[r], 0);
      else if (exp_vec[r])   chk(tr_cnt[r] == exp_tr[r], "R3 trials to pass", tr_cnt[r], exp_tr[r]);
      else                   chk(tr_cnt[r] == exp_tr[r], "R4 trials to fail", tr_cnt[r], exp_tr[r]);
      chk(rf_cnt[r] == ((r < nre - 1) ? rf : 0), "R5 refresh burst", rf_cnt[r],
          (r < nre - 1) ? rf : 0);
    end
  endtask

  task automatic step_pulse();
    dbg_step_wr = 1'b1;
    engine_cycle();
    dbg_step_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int reps[4] = '{0, 1, 2, 7};
    int rfs[3]  = '{0, 3, 8};
    int k;
    rst = 1'b1; cfg_we = 1'b0; cfg_rfsh_cnt = '0; cfg_repeat = '0; cfg_dbg_en = 1'b0;
    dbg_step_wr = 1'b0; num_ranks = 3'd1; start = 1'b0; trn_done = 1'b0;
    trn_pass = 1'b0; ref_ack = 1'b0; pat = 0; ack_dly = 0;
    clear_stats();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk(rfsh_cnt_q == 4'd8, "R1 refresh count", int'(rfsh_cnt_q), 8);
    chk(repeat_q == 4'd7, "R1 repeat count", int'(repeat_q), 7);
    chk(dbg_en_q == 1'b0, "R1 debug enable", int'(dbg_en_q), 0);
    chk(dbg_step_q == 1'b0, "R1 step bit", int'(dbg_step_q), 0);
    chk({trn_req, ref_req, seq_done, busy} == 4'b0, "R1 idle outputs",
        int'({trn_req, ref_req, seq_done, busy}), 0);

    k = 0;
    foreach (reps[i]) foreach (rfs[j])
      for (int nr = 1; nr <= 4; nr++)
        for (int p = 0; p < 3; p++) begin
          run(rfs[j], reps[i], nr, p, k % 3);
          k++;
        end
    run(2, 1, 0, 0, 1);  // R2 zero ranks act as one
    run(2, 2, 6, 1, 0);  // R2 oversize clamps to four

    // R8 / R9 single-step debug
    cfg_write(3, 1, 1'b1);
    num_ranks = 3'd1; pat = 0; ack_dly = 0;
    clear_stats();
    step_pulse();
    repeat (2) engine_cycle();
    chk(dbg_step_q == 1'b1, "R8 step pending in idle", int'(dbg_step_q), 1);
    start = 1'b1;
    engine_cycle();
    start = 1'b0;
    repeat (7) engine_cycle();
    chk(tr_cnt[0] == 1, "R8 first step issues one trial", tr_cnt[0], 1);
    chk(dbg_step_q == 1'b0, "R8 step consumed", int'(dbg_step_q), 0);
    repeat (12) engine_cycle();
    chk(busy == 1'b1 && done_cnt == 0, "R8 frozen without step", done_cnt, 0);
    step_pulse(); repeat (6) engine_cycle();
    chk(done_cnt == 0, "R9 no done after second step", done_cnt, 0);
    step_pulse(); repeat (6) engine_cycle();
    chk(done_cnt == 0, "R9 no done after third step", done_cnt, 0);
    step_pulse(); repeat (6) engine_cycle();
    chk(done_cnt == 1, "R9 done after fourth step", done_cnt, 1);
    chk(tr_cnt[0] == 1 && pass_seen == 4'b0001, "R9 single trial passed",
        int'(pass_seen), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule